// File: doc/BRIEF.md
# Serial EEPROM Write-Cycle Slave

This block is the device side of a three-wire serial EEPROM port: a chip select, a serial clock and a data input, plus a status output that can be switched off. It decodes write and write-enable control instructions, runs a timed programming cycle modelled by a counter of system clocks, and then updates an internal 128 x 16 array. The array can also be addressed as 256 bytes. The serial lines are sampled in the system clock domain, and a serial clock rising edge is found by comparing each sample with the one before.

A host shifts a frame in while select is high, then drops select. If select is later raised after a long enough low period, the status output reports busy (0) or ready (1) for as long as select stays high. Once the write has finished, a start bit followed by select going low dismisses the status. A parameter chooses whether programming starts when select falls after a complete frame, or on the serial clock edge that captures the last data bit.

Top module: `sep_write_slave`

## Requirements
- R1: While select is high, data is sampled on each serial clock rising edge. Zeros before the first 1 (the start bit) are skipped. After the start bit come a 2-bit opcode (01 = write), the address MSB first, then the data MSB first.
- R2: With `org16`=1 the address is 7 bits and the data 16 bits. With `org16`=0 the address is 8 bits and the data 8 bits; address bit 0 picks the byte lane (1 = bits 15:8), and bits 7:1 pick the word.
- R3: Opcode 00 is a control instruction. If the two address MSBs are 11 it enables writes, and if they are 00 it disables them. Writes are disabled after reset, and a write frame sent while writes are disabled leaves the array unchanged.
- R4: With START_ON_CS_FALL=1, programming starts when select falls after the last data bit. With START_ON_CS_FALL=0, it starts on the serial clock edge that captures the last data bit, even if select stays high.
- R5: If select falls before the last data bit arrives, the array is unchanged and no status becomes pending.
- R6: Programming lasts PROG_CYCLES system clocks. The addressed word or byte changes only when that time is over.
- R7: `sdo_en` is 0 whenever select is low.
- R8: When select rises after at least CSL_MIN clocks low while a write status is pending, `sdo_en` goes to 1 and `sdo` shows 0 while busy and 1 when ready. A shorter low period does not turn the output on.
- R9: When programming is over, a start bit followed by select falling clears the pending status, so later select-high periods leave `sdo_en` at 0.
- R10: A start bit received while busy causes the rest of that frame to be ignored. This applies to write and control frames alike.
- R11: After reset, `sdo_en` is 0, every array word is 0, and writes are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| org16 | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| sdo | output | 1 | Status: 0 busy, 1 ready |
| sdo_en | output | 1 | Output enable for sdo (0 = high impedance) |
| peek_addr | input | 7 | Word index for observing the array |
| peek_data | output | 16 | Array word at peek_addr |

## Verification
A bit counter that slips by one makes the captured data shift by one position. That shows up as a wrong `peek_data` word in the first clock after the programming time ends. A write-enable flag or frame state that is lost or stuck makes a write either land or vanish when it should not, which a reference array compared on every clock catches at that same point. Faults in the status logic show in the first clock after select rises: `sdo_en` or `sdo` differs from the model. Faults in the busy timer show as `sdo` changing one cycle early or late.

// File: rtl/sep_pkg.sv
package sep_pkg;
  typedef enum logic [1:0] {
    RX_HUNT,
    RX_SHIFT,
    RX_ARMED,
    RX_SKIP
  } rx_state_e;
endpackage

// File: rtl/sep_frame_rx.sv
module sep_frame_rx
  import sep_pkg::*;
#(
  parameter int ADDR_W           = 7,
  parameter int WORD_W           = 16,
  parameter bit START_ON_CS_FALL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csel,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              org16,
  input  logic              busy,
  output logic              start,
  output logic              clear_req,
  output logic              wr_org16,
  output logic [ADDR_W:0]   wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  localparam int HALF  = WORD_W / 2;
  localparam int HDR16 = 2 + ADDR_W;
  localparam int HDR8  = 3 + ADDR_W;
  localparam int FRM16 = HDR16 + WORD_W;
  localparam int FRM8  = HDR8 + HALF;
  localparam int SH_W  = (FRM16 > FRM8) ? FRM16 : FRM8;
  localparam int CNT_W = $clog2(SH_W + 1);

  rx_state_e         st_q, st_d;
  logic [SH_W-1:0]   sh_q, sh_d, sh_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc, hdr_len, frm_len;
  logic              wen_q, wen_d, cs_q, sclk_q, org_q, org_d;
  logic [ADDR_W:0]   addr_q, addr_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [1:0]        op, ctl;
  logic              rise, cs_fall;

  assign rise    = sclk & ~sclk_q;
  assign cs_fall = cs_q & ~csel;
  assign sh_nx   = {sh_q[SH_W-2:0], sdi};
  assign cnt_inc = cnt_q + 1'b1;
  assign hdr_len = org16 ? CNT_W'(HDR16) : CNT_W'(HDR8);
  assign frm_len = org16 ? CNT_W'(FRM16) : CNT_W'(FRM8);
  assign op      = org16 ? sh_nx[ADDR_W+1 -: 2] : sh_nx[ADDR_W+2 -: 2];
  assign ctl     = org16 ? sh_nx[ADDR_W-1 -: 2] : sh_nx[ADDR_W -: 2];

  always_comb begin
    st_d      = st_q;
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    wen_d     = wen_q;
    addr_d    = addr_q;
    data_d    = data_q;
    org_d     = org_q;
    start     = 1'b0;
    clear_req = 1'b0;
    if (!csel) begin
      st_d  = RX_HUNT;
      cnt_d = '0;
      if (cs_fall) begin
        if (st_q == RX_ARMED)                start     = 1'b1;
        else if (st_q != RX_HUNT && !busy)   clear_req = 1'b1;
      end
    end else if (rise) begin
      unique case (st_q)
        RX_HUNT: if (sdi) begin
          st_d  = busy ? RX_SKIP : RX_SHIFT;
          cnt_d = '0;
        end
        RX_SHIFT: begin
          sh_d  = sh_nx;
          cnt_d = cnt_inc;
          if (cnt_inc == hdr_len) begin
            if (op == 2'b00) begin
              if (ctl == 2'b11)      wen_d = 1'b1;
              else if (ctl == 2'b00) wen_d = 1'b0;
              st_d = RX_SKIP;
            end else if (!(op == 2'b01 && wen_q)) begin
              st_d = RX_SKIP;
            end
          end else if (cnt_inc == frm_len) begin
            org_d = org16;
            if (org16) begin
              addr_d = {1'b0, sh_nx[WORD_W+ADDR_W-1 -: ADDR_W]};
              data_d = sh_nx[WORD_W-1:0];
            end else begin
              addr_d = sh_nx[HALF+ADDR_W -: ADDR_W+1];
              data_d = {{(WORD_W-HALF){1'b0}}, sh_nx[HALF-1:0]};
            end
            if (START_ON_CS_FALL) begin
              st_d = RX_ARMED;
            end else begin
              start = 1'b1;
              st_d  = RX_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_HUNT;
      sh_q   <= '0;
      cnt_q  <= '0;
      wen_q  <= 1'b0;
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
      org_q  <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      wen_q  <= wen_d;
      cs_q   <= csel;
      sclk_q <= sclk;
      org_q  <= org_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_org16 = org_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
endmodule

// File: rtl/sep_prog_timer.sv
module sep_prog_timer #(
  parameter int PROG_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic commit
);
  localparam int TC_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

  logic            busy_q, busy_d;
  logic [TC_W-1:0] tc_q, tc_d;

  assign commit = busy_q && (tc_q == '0);

  always_comb begin
    busy_d = busy_q;
    tc_d   = tc_q;
    if (start) begin
      busy_d = 1'b1;
      tc_d   = TC_W'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (tc_q == '0) busy_d = 1'b0;
      else            tc_d   = tc_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tc_q   <= '0;
    end else begin
      busy_q <= busy_d;
      tc_q   <= tc_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/sep_cell_array.sv
module sep_cell_array #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              wr_org16,
  input  logic [ADDR_W:0]   waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [WORD_W-1:0] peek_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = WORD_W / 2;

  logic [DEPTH*WORD_W-1:0] flat;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic [WORD_W-1:0] w_q, w_d;
    logic              hit;
    always_comb begin
      hit = we && (wr_org16 ? (waddr[ADDR_W-1:0] == ADDR_W'(gi))
                            : (waddr[ADDR_W:1]   == ADDR_W'(gi)));
      w_d = w_q;
      if (hit) begin
        if (wr_org16)      w_d = wdata;
        else if (waddr[0]) w_d[WORD_W-1:HALF] = wdata[HALF-1:0];
        else               w_d[HALF-1:0]      = wdata[HALF-1:0];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_q <= '0;
      else        w_q <= w_d;
    end
    assign flat[gi*WORD_W +: WORD_W] = w_q;
  end

  assign peek_data = flat[peek_addr*WORD_W +: WORD_W];
endmodule

// File: rtl/sep_write_slave.sv
module sep_write_slave #(
  parameter int ADDR_W           = 7,
  parameter int WORD_W           = 16,
  parameter int PROG_CYCLES      = 40,
  parameter int CSL_MIN          = 4,
  parameter bit START_ON_CS_FALL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csel,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              org16,
  output logic              sdo,
  output logic              sdo_en,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [WORD_W-1:0] peek_data
);
  localparam int CSL_W = $clog2(CSL_MIN + 1);

  logic              rs1_q, rst_sn;
  logic              start_w, clear_w, busy_w, commit_w, wr_org_w;
  logic [ADDR_W:0]   wr_addr_w;
  logic [WORD_W-1:0] wr_data_w;
  logic              cs_q, pend_q, pend_d, vis_q, vis_d;
  logic [CSL_W-1:0]  csl_q, csl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      rst_sn <= rs1_q;
    end
  end

  sep_frame_rx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .START_ON_CS_FALL(START_ON_CS_FALL)) u_rx (
    .clk(clk), .rst_n(rst_sn), .csel(csel), .sclk(sclk), .sdi(sdi), .org16(org16),
    .busy(busy_w), .start(start_w), .clear_req(clear_w), .wr_org16(wr_org_w),
    .wr_addr(wr_addr_w), .wr_data(wr_data_w)
  );

  sep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sn), .start(start_w), .busy(busy_w), .commit(commit_w)
  );

  sep_cell_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk(clk), .rst_n(rst_sn), .we(commit_w), .wr_org16(wr_org_w), .waddr(wr_addr_w),
    .wdata(wr_data_w), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  always_comb begin
    csl_d  = csel ? '0 : ((csl_q == CSL_W'(CSL_MIN)) ? csl_q : csl_q + 1'b1);
    pend_d = pend_q;
    if (start_w)      pend_d = 1'b1;
    else if (clear_w) pend_d = 1'b0;
    vis_d = vis_q;
    if (!csel && cs_q) vis_d = 1'b0;
    else if (csel && !cs_q && (csl_q >= CSL_W'(CSL_MIN)) && pend_q) vis_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cs_q   <= 1'b0;
      csl_q  <= '0;
      pend_q <= 1'b0;
      vis_q  <= 1'b0;
    end else begin
      cs_q   <= csel;
      csl_q  <= csl_d;
      pend_q <= pend_d;
      vis_q  <= vis_d;
    end
  end

  assign sdo_en = vis_q & csel;
  assign sdo    = ~busy_w;
endmodule

// File: rtl/sep_write_slave_chk.sv
module sep_write_slave_chk #(
  parameter int PROG_CYCLES = 40,
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              commit,
  input logic [ADDR_W-1:0] peek_addr,
  input logic [WORD_W-1:0] peek_data
);
  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R6
  prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == PROG_CYCLES));

  // R5
  array_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> (!$stable(peek_addr) || $stable(peek_data)));
endmodule

bind sep_write_slave sep_write_slave_chk #(
  .PROG_CYCLES(PROG_CYCLES), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_sn), .start(start_w), .busy(busy_w), .commit(commit_w),
  .peek_addr(peek_addr), .peek_data(peek_data)
);

// File: tb/test_sep_write_slave.sv
module test_sep_write_slave;
  localparam int AW = 7, PROG = 40, CSLM = 4;
  localparam int S_HUNT = 0, S_SHIFT = 1, S_ARM = 2, S_SKIP = 3;

  logic clk = 1'b0;
  logic rst_n, csel, sclk, sdi, org16;
  logic [6:0]  peek_addr;
  logic        sdo, sdo_en, sdo2, sdo_en2;
  logic [15:0] peek_data, peek2;
  int vectors = 0, fails = 0;

  always #5 clk = ~clk;

  sep_write_slave #(.PROG_CYCLES(PROG), .CSL_MIN(CSLM), .START_ON_CS_FALL(1'b1)) i_sep_write_slave (
    .clk(clk), .rst_n(rst_n), .csel(csel), .sclk(sclk), .sdi(sdi), .org16(org16),
    .sdo(sdo), .sdo_en(sdo_en), .peek_addr(peek_addr), .peek_data(peek_data));

  sep_write_slave #(.PROG_CYCLES(PROG), .CSL_MIN(CSLM), .START_ON_CS_FALL(1'b0)) i_sep_write_slave_v0 (
    .clk(clk), .rst_n(rst_n), .csel(csel), .sclk(sclk), .sdi(sdi), .org16(org16),
    .sdo(sdo2), .sdo_en(sdo_en2), .peek_addr(peek_addr), .peek_data(peek2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference for the START_ON_CS_FALL=1 instance
  int m_st, m_tc, m_csl, m_addr, m_data;
  bit m_wen, m_busy, m_pend, m_vis, m_org, p_cs, p_sclk;
  bit m_q[$];
  int m_mem[128];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = S_HUNT; m_tc = 0; m_csl = 0; m_wen = 0; m_busy = 0; m_pend = 0;
      m_vis = 0; p_cs = 0; p_sclk = 0; m_addr = 0; m_data = 0; m_org = 1;
      m_q.delete();
      foreach (m_mem[k]) m_mem[k] = 0;
    end else begin
      bit ob, go, clr, rise, fall, crise;
      int aw, dw, n, op, ctl;
      ob = m_busy; go = 0; clr = 0;
      rise = sclk && !p_sclk; fall = !csel && p_cs; crise = csel && !p_cs;
      aw = org16 ? AW : AW + 1;
      dw = org16 ? 16 : 8;
      if (m_busy) begin
        if (m_tc == 0) begin
          m_busy = 0;
          if (m_org) m_mem[m_addr] = m_data;
          else if (m_addr % 2 == 1) m_mem[m_addr/2] = (m_mem[m_addr/2] & 'h00FF) | (m_data << 8);
          else m_mem[m_addr/2] = (m_mem[m_addr/2] & 'hFF00) | m_data;
        end else m_tc--;
      end
      if (!csel) begin
        if (fall) begin
          if (m_st == S_ARM) go = 1;
          else if (m_st != S_HUNT && !ob) clr = 1;
        end
        m_st = S_HUNT;
        m_q.delete();
      end else if (rise) begin
        if (m_st == S_HUNT) begin
          if (sdi) m_st = ob ? S_SKIP : S_SHIFT;
        end else if (m_st == S_SHIFT) begin
          m_q.push_back(sdi);
          n = m_q.size();
          if (n == 2 + aw) begin
            op = m_q[0] * 2 + m_q[1];
            ctl = m_q[2] * 2 + m_q[3];
            if (op == 0) begin
              if (ctl == 3) m_wen = 1; else if (ctl == 0) m_wen = 0;
              m_st = S_SKIP;
            end else if (!(op == 1 && m_wen)) m_st = S_SKIP;
          end else if (n == 2 + aw + dw) begin
            m_addr = 0; m_data = 0;
            for (int i = 0; i < aw; i++) m_addr = m_addr * 2 + m_q[2+i];
            for (int i = 0; i < dw; i++) m_data = m_data * 2 + m_q[2+aw+i];
            m_org = org16;
            m_st = S_ARM;
          end
        end
      end
      if (fall) m_vis = 0;
      else if (crise && m_csl >= CSLM && m_pend) m_vis = 1;
      m_csl = csel ? 0 : (m_csl < CSLM ? m_csl + 1 : m_csl);
      if (go) begin m_busy = 1; m_tc = PROG - 1; m_pend = 1; end
      else if (clr) m_pend = 0;
      p_cs = csel; p_sclk = sclk;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R7/R8 sdo_en vs model", 32'(sdo_en), 32'(m_vis && csel));
      if (m_vis && csel) chk("R8 sdo vs model", 32'(sdo), 32'(!m_busy));
      chk("R6 peek vs model", 32'(peek_data), 32'(m_mem[peek_addr]));
    end
  end

  task automatic sbits(input int nb, input int v);
    for (int i = nb - 1; i >= 0; i--) begin
      @(negedge clk) sclk = 1'b0; sdi = v[i];
      @(negedge clk) sclk = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk) csel = 1'b1; sclk = 1'b0; sdi = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_off(input int n);
    @(negedge clk) csel = 1'b0; sclk = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_frame(input int lead, input int addr, input int data, input int nd);
    int aw, dw;
    aw = org16 ? AW : AW + 1;
    dw = org16 ? 16 : 8;
    cs_on();
    if (lead > 0) sbits(lead, 0);
    sbits(1, 1);
    sbits(2, 1);
    sbits(aw, addr);
    sbits(nd, data >> (dw - nd));
  endtask

  task automatic ctl_frame(input bit en);
    cs_on();
    sbits(1, 1);
    sbits(2, 0);
    sbits(AW, en ? 7'b1100000 : 0);
    cs_off(8);
  endtask

  task automatic raise_cs();
    @(negedge clk) csel = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic peek(input int a);
    @(negedge clk) peek_addr = 7'(a);
    #1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; vectors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; csel = 1'b0; sclk = 1'b0; sdi = 1'b0; org16 = 1'b1; peek_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R11 reset state
    chk("R11 sdo_en after reset", 32'(sdo_en), 0);
    chk("R11 array after reset", 32'(peek_data), 0);

    // R3 write while disabled
    wr_frame(0, 5, 'hA5A5, 16);
    cs_off(PROG + 10);
    peek(5);
    chk("R3 disabled write ignored", 32'(peek_data), 0);
    raise_cs();
    chk("R3 no status after ignored write", 32'(sdo_en), 0);

    // R1 leading zeros, R4 start event
    ctl_frame(1);
    wr_frame(3, 5, 'h1234, 16);
    repeat (PROG + 5) @(negedge clk);
    #1;
    chk("R4 cs-fall variant waits", 32'(peek_data), 0);
    chk("R4 clock-edge variant programmed", 32'(peek2), 'h1234);
    cs_off(CSLM + 1);
    #1;
    chk("R7 sdo_en low with select low", 32'(sdo_en), 0);
    raise_cs();
    chk("R8 status on", 32'(sdo_en), 1);
    chk("R8 busy shown", 32'(sdo), 0);
    repeat (PROG) @(negedge clk);
    #1;
    chk("R8 ready shown", 32'(sdo), 1);
    chk("R1 R6 word written", 32'(peek_data), 'h1234);

    // R8 short low period
    cs_off(2);
    raise_cs();
    chk("R8 short low keeps output off", 32'(sdo_en), 0);
    cs_off(6);
    raise_cs();
    chk("R8 long low shows ready", 32'(sdo_en & sdo), 1);

    // R9 clear status
    sbits(1, 1);
    cs_off(6);
    raise_cs();
    chk("R9 status cleared", 32'(sdo_en), 0);

    // R2 byte organisation
    org16 = 1'b0;
    wr_frame(0, 'h0B, 'h77, 8);
    cs_off(PROG + 5);
    wr_frame(0, 'h0A, 'h34, 8);
    cs_off(PROG + 5);
    peek(5);
    chk("R2 byte lanes", 32'(peek_data), 'h7734);
    org16 = 1'b1;

    // R5 aborted write
    wr_frame(0, 3, 'hFFFF, 6);
    cs_off(PROG + 5);
    peek(3);
    chk("R5 aborted write", 32'(peek_data), 0);
    raise_cs();
    chk("R5 no status after abort", 32'(sdo_en), 0);

    // R10 control and write frames while busy
    wr_frame(0, 6, 'hBEEF, 16);
    cs_off(2);
    ctl_frame(0);
    cs_off(PROG);
    wr_frame(0, 7, 'h1111, 16);
    cs_off(PROG + 5);
    peek(7);
    chk("R10 disable ignored while busy", 32'(peek_data), 'h1111);
    wr_frame(0, 8, 'h2222, 16);
    cs_off(2);
    wr_frame(0, 9, 'h3333, 16);
    cs_off(PROG + 5);
    peek(9);
    chk("R10 write ignored while busy", 32'(peek_data), 0);
    peek(8);
    chk("R10 first write kept", 32'(peek_data), 'h2222);

    // R3 disable then write
    ctl_frame(0);
    wr_frame(0, 10, 'h4444, 16);
    cs_off(PROG + 5);
    peek(10);
    chk("R3 write after disable", 32'(peek_data), 0);

    summary();
  end
endmodule